// File: doc/BRIEF.md
# Dual-Lane Packed FIR Engine

This block computes one output sample of a short FIR filter on request. It forms the dot product of a coefficient vector with the most recent input samples, which are held in a ring buffer whose write pointer wraps modulo a power-of-two depth. Coefficients are loaded as packed 32-bit words, each holding two signed 16-bit taps. The sample side reads two neighbouring samples in each cycle, so the engine forms two products per cycle in two parallel lanes.

Products for even-numbered taps collect in one wide accumulator and products for odd-numbered taps collect in a second one. The two accumulators are added only after the last pair has been processed. The merged sum is scaled by dropping fifteen fraction bits and is clamped to 16 bits.

A system loads the coefficients and streams samples through a valid/ready handshake. When it wants a new output it pulses `start`, and it reads `y_data` in the cycle in which `y_valid` is high.

Top module: `fir_pair_engine`

## Requirements
- R1: While reset is held and after reset is released, `y_valid` is 0, `y_data` is 0 and `smp_ready` is 1. Every stored sample and coefficient reads as zero.
- R2: A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both 1. It becomes the newest sample x(n) and replaces the oldest of the NTAPS stored samples, and the write position wraps modulo NTAPS.
- R3: A write with `coef_we` high to pair index k sets tap a(2k) from `coef_wdata[15:0]` and tap a(2k+1) from `coef_wdata[31:16]`. Both taps are signed 16-bit values.
- R4: The result is derived from the sum over i from 0 to NTAPS-1 of a(i)·x(n-i), taken over the samples accepted before the start edge. A sample position never written since reset counts as zero.
- R5: Even-tap products and odd-tap products are kept in two separate signed 40-bit accumulators. Both are cleared when a run starts, so a result never carries anything over from an earlier run. Neither accumulator overflows.
- R6: `y_valid` is high for exactly one cycle per accepted start.
- R7: `y_data` equals bits [30:15] of the merged sum, which is a floor shift by 15. A value above 32767 is clamped to 32767 and a value below -32768 is clamped to -32768.
- R8: While a run is in progress, `smp_ready` is 0, a `start` pulse has no effect, and a sample offered on `smp_valid` is not stored.
- R9: A run takes NTAPS/2 accumulation cycles, counted down to zero, plus one merge cycle. If `start` is sampled at clock edge E, `y_valid` is high after edge E+NTAPS/2+1, and a new `start` is accepted from the next edge onward.
- R10: `y_data` keeps the last result until the next `y_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Input sample offered |
| smp_data | input | 16 | Signed input sample |
| smp_ready | output | 1 | Engine idle and able to take a sample |
| coef_we | input | 1 | Coefficient pair write strobe |
| coef_addr | input | log2(NTAPS/2) | Coefficient pair index k |
| coef_wdata | input | 32 | Packed taps: a(2k) in the low half, a(2k+1) in the high half |
| start | input | 1 | Request one output computation |
| y_valid | output | 1 | One-cycle result strobe |
| y_data | output | 16 | Signed, scaled and saturated result |

## Verification
The assertions assume that coefficient writes arrive only while the engine is idle. The stimulus follows this rule: the bench writes coefficients only between runs, after `y_valid` has pulsed. The bench never changes the tap count at run time. The one stimulus outside normal use is the deliberate raising of `start` and `smp_valid` in the middle of a run. Its purpose is to show that both are dropped. The accumulator headroom check relies on 16-bit signed operands and at most 256 taps, and the elaboration guards enforce both limits.

// File: rtl/fir_pair_pkg.sv
package fir_pair_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_MERGE = 2'd2
   } fir_state_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/fir_pair_coef_bank.sv
module fir_pair_coef_bank #(
   parameter int NPAIR = 4,
   parameter int DW    = 16,
   localparam int PW   = fir_pair_pkg::idx_w(NPAIR)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PW-1:0]   waddr,
   input  logic [2*DW-1:0] wdata,
   input  logic [PW-1:0]   raddr,
   output logic [2*DW-1:0] rdata
);
   logic [2*DW-1:0] mem [NPAIR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPAIR; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fir_pair_ring.sv
module fir_pair_ring #(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   localparam int LW   = fir_pair_pkg::idx_w(DEPTH),
   localparam int PW   = fir_pair_pkg::idx_w(DEPTH/2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [DW-1:0]   wdata,
   input  logic [PW-1:0]   pair_idx,
   output logic [2*DW-1:0] pair_word,
   output logic [LW-1:0]   wptr
);
   logic [DW-1:0] mem [DEPTH];
   logic [LW-1:0] lo_pos, hi_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         wptr <= '0;
      end else if (we) begin
         mem[wptr] <= wdata;
         wptr      <= wptr + LW'(1);
      end
   end

   // newest sample sits one behind the write pointer; pair k holds x(n-2k), x(n-2k-1)
   assign lo_pos    = wptr - LW'(1) - LW'({pair_idx, 1'b0});
   assign hi_pos    = lo_pos - LW'(1);
   assign pair_word = {mem[hi_pos], mem[lo_pos]};

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wptr == LW'(DEPTH-1)) |=> (wptr == '0));
endmodule

// File: rtl/fir_pair_lane.sv
module fir_pair_lane #(
   parameter int DW = 16,
   parameter int AW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [DW-1:0] coef,
   input  logic signed [DW-1:0] samp,
   output logic signed [AW-1:0] acc
);
   logic signed [2*DW-1:0] prod;

   assign prod = coef * samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + AW'(prod);
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc[AW-1] == acc[AW-2]);
endmodule

// File: rtl/fir_pair_ctrl.sv
module fir_pair_ctrl #(
   parameter int NPAIR = 4,
   localparam int PW   = fir_pair_pkg::idx_w(NPAIR),
   localparam int CW   = $clog2(NPAIR + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          idle,
   output logic          clr,
   output logic          run,
   output logic          merge,
   output logic [PW-1:0] pair_idx
);
   import fir_pair_pkg::*;

   fir_state_e    state;
   logic [CW-1:0] cnt;

   assign idle     = (state == ST_IDLE);
   assign run      = (state == ST_RUN);
   assign merge    = (state == ST_MERGE);
   assign clr      = idle && start;
   assign pair_idx = PW'(CW'(NPAIR) - cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_RUN;
               cnt   <= CW'(NPAIR);
            end
            ST_RUN: begin
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) state <= ST_MERGE;
            end
            ST_MERGE: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0 && cnt <= CW'(NPAIR)));
   assert_last_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == CW'(1)) |=> merge);
   assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !$past(run)) |-> $past(idle));
endmodule

// File: rtl/fir_pair_engine.sv
module fir_pair_engine #(
   parameter int NTAPS    = 8,
   parameter int DW       = 16,
   parameter int AW       = 40,
   parameter int FRAC     = 15,
   parameter bit SATURATE = 1'b1,
   localparam int NPAIR   = NTAPS / 2,
   localparam int PW      = fir_pair_pkg::idx_w(NPAIR),
   localparam int LW      = fir_pair_pkg::idx_w(NTAPS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic [DW-1:0]   smp_data,
   output logic            smp_ready,
   input  logic            coef_we,
   input  logic [PW-1:0]   coef_addr,
   input  logic [2*DW-1:0] coef_wdata,
   input  logic            start,
   output logic            y_valid,
   output logic [DW-1:0]   y_data
);
   if (NTAPS < 2 || (NTAPS & (NTAPS - 1)) != 0) begin : g_bad_taps
      $error("NTAPS must be a power of two, at least 2");
   end
   if (NTAPS > 256) begin : g_bad_max
      $error("NTAPS above 256 exceeds accumulator headroom");
   end
   if (AW < 2*DW + $clog2(NTAPS) + 1) begin : g_bad_aw
      $error("AW too narrow for NTAPS products");
   end
   if (FRAC + DW > AW) begin : g_bad_frac
      $error("FRAC + DW exceeds AW");
   end

   logic                 idle, clr, run, merge;
   logic [PW-1:0]        pair_idx;
   logic [2*DW-1:0]      coef_word, samp_word;
   logic [LW-1:0]        wptr;
   logic signed [AW-1:0] acc [2];
   logic signed [AW-1:0] sum;
   logic [DW-1:0]        y_next;

   assign smp_ready = idle;

   fir_pair_ctrl #(.NPAIR(NPAIR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .clr(clr),
      .run(run), .merge(merge), .pair_idx(pair_idx)
   );

   fir_pair_coef_bank #(.NPAIR(NPAIR), .DW(DW)) u_coef (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
      .wdata(coef_wdata), .raddr(pair_idx), .rdata(coef_word)
   );

   fir_pair_ring #(.DEPTH(NTAPS), .DW(DW)) u_ring (
      .clk(clk), .rst_n(rst_n), .we(smp_valid && idle), .wdata(smp_data),
      .pair_idx(pair_idx), .pair_word(samp_word), .wptr(wptr)
   );

   // lane 0: even taps (low halves), lane 1: odd taps (high halves)
   for (genvar g = 0; g < 2; g++) begin : g_lane
      fir_pair_lane #(.DW(DW), .AW(AW)) u_lane (
         .clk(clk), .rst_n(rst_n), .clr(clr), .en(run),
         .coef(coef_word[g*DW +: DW]), .samp(samp_word[g*DW +: DW]),
         .acc(acc[g])
      );
   end

   assign sum = acc[0] + acc[1];

   if (SATURATE) begin : g_sat
      localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
      localparam logic signed [AW-1:0] YMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
      logic signed [AW-1:0] scaled;
      assign scaled = sum >>> FRAC;
      always_comb begin
         if (scaled > YMAX)      y_next = YMAX[DW-1:0];
         else if (scaled < YMIN) y_next = YMIN[DW-1:0];
         else                    y_next = scaled[DW-1:0];
      end
   end else begin : g_wrap
      assign y_next = sum[FRAC +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_valid <= 1'b0;
         y_data  <= '0;
      end else begin
         y_valid <= merge;
         if (merge) y_data <= y_next;
      end
   end

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |=> !y_valid);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !y_valid |-> $stable(y_data));
   assert_no_store_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_ready |=> $stable(wptr));
   assert_idle_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> smp_ready);
endmodule

// File: tb/fir_pair_engine_test.sv
`timescale 1ns/1ps
module fir_pair_engine_test;
   localparam int NT = 8;
   localparam int NP = NT / 2;
   localparam int PW = $clog2(NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [15:0]   smp_data = '0;
   logic          smp_ready;
   logic          coef_we = 1'b0;
   logic [PW-1:0] coef_addr = '0;
   logic [31:0]   coef_wdata = '0;
   logic          start = 1'b0;
   logic          y_valid;
   logic [15:0]   y_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit live = 1'b0;

   // behavioural model state
   int     m_coef [NT];
   int     m_hist [$];
   int     m_phase = 0;
   int     m_res = 0;
   bit     m_valid = 1'b0;
   int     m_data = 0;

   always #2.5 clk = ~clk;

   fir_pair_engine #(.NTAPS(NT)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ready(smp_ready), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .start(start), .y_valid(y_valid), .y_data(y_data)
   );

   function automatic int expect_result();
      longint s = 0;
      longint q;
      for (int i = 0; i < NT; i++) begin
         if (i < m_hist.size()) s += longint'(m_coef[i]) * longint'(m_hist[i]);
      end
      q = s >>> 15;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return int'(q);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NT; i++) m_coef[i] = 0;
         m_hist.delete();
         m_phase = 0; m_valid = 1'b0; m_data = 0;
      end else begin
         m_valid = 1'b0;
         if (coef_we) begin
            m_coef[2*coef_addr]   = int'($signed(coef_wdata[15:0]));
            m_coef[2*coef_addr+1] = int'($signed(coef_wdata[31:16]));
         end
         if (m_phase == 0) begin
            if (smp_valid) begin
               m_hist.push_front(int'($signed(smp_data)));
               if (m_hist.size() > NT) void'(m_hist.pop_back());
            end
            if (start) begin
               m_res = expect_result();
               m_phase = NP + 1;
            end
         end else begin
            m_phase--;
            if (m_phase == 0) begin
               m_valid = 1'b1;
               m_data = m_res;
            end
         end
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (live && rst_n) begin
         chk(y_valid == m_valid, "R6 y_valid", int'(y_valid), int'(m_valid));
         chk(smp_ready == (m_phase == 0), "R8 smp_ready", int'(smp_ready), int'(m_phase == 0));
         chk(int'($signed(y_data)) == m_data, "R4 R7 R10 y_data", int'($signed(y_data)), m_data);
      end
   end

   task automatic push(input int v);
      smp_valid = 1'b1; smp_data = 16'(v);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic wcoef(input int k, input int lo, input int hi);
      coef_we = 1'b1; coef_addr = PW'(k); coef_wdata = {16'(hi), 16'(lo)};
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   task automatic go(input string req, input int exp, input bit poke);
      int n;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!y_valid && n < 50) begin
         if (poke && n == 2) begin start = 1'b1; smp_valid = 1'b1; smp_data = 16'd777; end
         else begin start = 1'b0; smp_valid = 1'b0; end
         @(negedge clk);
         n++;
      end
      start = 1'b0; smp_valid = 1'b0;
      chk(n == NP + 2, "R9 latency", n, NP + 2);
      chk(int'($signed(y_data)) == exp, req, int'($signed(y_data)), exp);
      @(negedge clk);
      chk(!y_valid, "R6 single pulse", int'(y_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(y_valid == 1'b0, "R1 y_valid in reset", int'(y_valid), 0);
      chk(y_data == '0, "R1 y_data in reset", int'(y_data), 0);
      chk(smp_ready == 1'b1, "R1 smp_ready in reset", int'(smp_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1'b1;
      chk(smp_ready == 1'b1, "R1 ready after reset", int'(smp_ready), 1);

      // R1: nothing stored yet -> zero result
      go("R1 zero state result", 0, 1'b0);

      // R4 four-tap reference: taps 2,1,1,1 scaled by 8192
      wcoef(0, 16384, 8192);
      wcoef(1, 8192, 8192);
      push(4000); push(3000); push(2000); push(1000);
      go("R4 reference four-tap", (2*1000 + 2000 + 3000 + 4000) * 8192 / 32768, 1'b0);

      // R3: only high half of pair 0 -> odd tap a(1) picks x(n-1)
      wcoef(0, 0, 32767);
      wcoef(1, 0, 0);
      go("R3 high half is odd tap", int'((longint'(32767) * 2000) >>> 15), 1'b0);

      // R5: even lane only, then odd lane only (no carry-over between runs)
      wcoef(0, 16384, 0);
      go("R5 even lane only", 500, 1'b0);
      wcoef(0, 0, 0);
      wcoef(1, 0, 16384);
      go("R5 odd lane only cleared", 2000, 1'b0);

      // R2: push more than NT samples so the ring wraps
      for (int k = 0; k < NP; k++) wcoef(k, 4096 * (k + 1), -4096 * (k + 1));
      for (int i = 0; i < 13; i++) push(100 * i - 500);
      go("R2 ring wrap", expect_result(), 1'b0);

      // R8: start and sample offered mid-run are dropped
      go("R8 busy pokes ignored", expect_result(), 1'b1);
      go("R8 state unchanged by pokes", expect_result(), 1'b0);

      // R7: positive and negative saturation
      for (int k = 0; k < NP; k++) wcoef(k, 32767, 32767);
      for (int i = 0; i < NT; i++) push(32767);
      go("R7 positive clamp", 32767, 1'b0);
      for (int i = 0; i < NT; i++) push(-32768);
      go("R7 negative clamp", -32768, 1'b0);

      // R7: floor shift on a negative, unsaturated value
      for (int k = 0; k < NP; k++) wcoef(k, 0, 0);
      wcoef(0, 1, 0);
      push(-3);
      go("R7 floor shift", -1, 1'b0);

      // R4: random mixes, sample and start on the same edge
      for (int t = 0; t < 6; t++) begin
         for (int k = 0; k < NP; k++) wcoef(k, int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
         for (int i = 0; i < 3 + t; i++) push(int'($urandom_range(65535)) - 32768);
         smp_valid = 1'b1; smp_data = 16'($urandom_range(65535));
         begin
            int e;
            m_hist.push_front(int'($signed(smp_data)));
            e = expect_result();
            void'(m_hist.pop_front());
            go("R4 random dot product", e, 1'b0);
         end
         smp_valid = 1'b0;
      end

      // R10: output holds while idle
      repeat (5) @(negedge clk);
      chk(int'($signed(y_data)) == m_data, "R10 hold while idle", int'($signed(y_data)), m_data);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule